// File: doc/BRIEF.md
# Multi-Line Page Write Cache

This block sits between a serial slave front-end and a nonvolatile array write port. It buffers a burst of data bytes and commits them to the array in one pass. The front-end opens a burst with a start request that carries a 13-bit word address. The cache splits that address into a fixed upper page and a six-bit slot pointer. The pointer is made of a three-bit line index above a three-bit byte offset, which gives eight lines of eight bytes. Each accepted byte is stored at the current slot, the slot is marked valid, and the six-bit pointer advances. The page bits never change during a burst.

A stop request ends the burst and starts the commit. A priority picker drains the valid slots one per cycle in ascending slot order. Each slot drives a write strobe, an address made of the page joined with the slot index, and the stored byte. After the last byte a settle delay follows, and busy stays high through it. An abort discards everything that was captured. While busy is high, new requests are ignored.

Top module: `page_write_cache`

## Requirements
- R1: A start request accepted while idle latches `start_addr`. The first byte that follows is stored at slot `start_addr[5:0]`, and it is committed to address `start_addr`.
- R2: Each accepted byte advances the six-bit slot pointer by one. When the offset (bits 2:0) passes 7, the pointer moves to offset 0 of the next line (bits 5:3). For example, start offset 6 followed by three bytes fills slots 6, 7 and 8.
- R3: After slot 63 the pointer wraps to slot 0. A later byte for an already written slot replaces the earlier one, and only the latest value is committed.
- R4: Bits 12:6 of every committed address equal bits 12:6 of the latched start address. Bits 5:0 are the slot index, and the data is the byte stored in that slot.
- R5: A stop during a burst starts the commit. Only slots written in this burst are sent, one per cycle, in strictly ascending slot index, with `arr_we` high only while `busy` is high.
- R6: A burst with a single byte commits exactly that one byte.
- R7: `busy` rises in the cycle after the stop is sampled. It stays high for N + 1 + SETTLE_CYCLES cycles, where N is the number of distinct slots written. With N = 0 there are no array writes.
- R8: An abort during a burst returns the block to idle. It makes no array writes, does not raise `busy`, and leaves no stale bytes for the next burst.
- R9: Start, byte and stop requests are ignored while `busy` is high. Byte and stop requests are also ignored while idle.
- R10: When abort and stop arrive in the same cycle, abort wins. A byte that arrives in the same cycle as a stop is not captured.
- R11: After reset, `busy` and `arr_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_start | input | 1 | Open a write burst (honoured only when idle) |
| start_addr | input | 13 | Starting word address of the burst |
| byte_valid | input | 1 | Incoming data byte is present |
| byte_data | input | 8 | Incoming data byte |
| stop_in | input | 1 | End the burst and commit |
| abort_in | input | 1 | End the burst and discard |
| busy | output | 1 | Commit or settle in progress |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | 13 | Array write address |
| arr_data | output | 8 | Array write data |

## Verification
A wrong slot pointer or a wrong page latch shows up only at commit. It appears as wrong low or high bits on `arr_addr`, or as data paired with the wrong address, starting in the cycle after `busy` rises. A corrupted valid mask shows up as missing, extra or stale writes. It also changes the length of the busy window by the same number of cycles, so a count of busy cycles catches it even when the data looks plausible. Ordering faults in the picker show up as a non-ascending address sequence within the N write cycles.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

    localparam int DEF_ADDR_W     = 13;
    localparam int DEF_DATA_W     = 8;
    localparam int DEF_LINES      = 8;
    localparam int DEF_LINE_BYTES = 8;
    localparam int DEF_SETTLE     = 4;

    typedef enum logic [1:0] {
        PWC_IDLE   = 2'd0,
        PWC_FILL   = 2'd1,
        PWC_DRAIN  = 2'd2,
        PWC_SETTLE = 2'd3
    } pwc_state_e;

    // Decoded per-cycle actions of the controller.
    typedef struct packed {
        logic open;       // accept a new burst
        logic take_byte;  // store incoming byte
        logic go_commit;  // stop accepted
        logic discard;    // abort accepted
    } pwc_ctrl_t;

    function automatic pwc_ctrl_t decode_ctrl(
        input pwc_state_e st,
        input logic       start,
        input logic       bv,
        input logic       stp,
        input logic       abt
    );
        pwc_ctrl_t c;
        c.open      = (st == PWC_IDLE) && start;
        c.discard   = (st == PWC_FILL) && abt;
        c.go_commit = (st == PWC_FILL) && !abt && stp;
        c.take_byte = (st == PWC_FILL) && !abt && !stp && bv;
        return c;
    endfunction

    function automatic logic is_busy(input pwc_state_e st);
        return (st == PWC_DRAIN) || (st == PWC_SETTLE);
    endfunction

endpackage

// File: rtl/pwc_addr_track.sv
module pwc_addr_track #(
    parameter int ADDR_W = 13,
    parameter int IDX_W  = 6,
    localparam int PAGE_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              bump,
    output logic [PAGE_W-1:0] page,
    output logic [IDX_W-1:0]  ptr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            page <= '0;
            ptr  <= '0;
        end else if (load) begin
            page <= load_addr[ADDR_W-1:IDX_W];
            ptr  <= load_addr[IDX_W-1:0];
        end else if (bump) begin
            // Plain modulo count: offset carries into the line index,
            // line index wraps back to slot 0.
            ptr <= ptr + 1'b1;
        end
    end

endmodule

// File: rtl/pwc_slot_store.sv
module pwc_slot_store #(
    parameter int DATA_W = 8,
    parameter int SLOTS  = 64,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_all,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [SLOTS-1:0]  mask
);

    logic [DATA_W-1:0] data_q [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic              v_q;
        logic [DATA_W-1:0] d_q;
        logic              hit_wr;
        logic              hit_clr;

        assign hit_wr  = wr_en  && (wr_idx  == IDX_W'(s));
        assign hit_clr = clr_en && (clr_idx == IDX_W'(s));

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                d_q <= '0;
            end else if (clr_all) begin
                v_q <= 1'b0;
            end else if (hit_wr) begin
                v_q <= 1'b1;
                d_q <= wr_data;
            end else if (hit_clr) begin
                v_q <= 1'b0;
            end
        end

        assign mask[s]   = v_q;
        assign data_q[s] = d_q;
    end

    assign rd_data = data_q[rd_idx];

endmodule

// File: rtl/pwc_drain_port.sv
module pwc_drain_port #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    parameter int SLOTS  = 64,
    localparam int IDX_W  = $clog2(SLOTS),
    localparam int PAGE_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [SLOTS-1:0]  mask,
    input  logic [PAGE_W-1:0] page,
    input  logic [DATA_W-1:0] rd_data,
    output logic              pick_any,
    output logic [IDX_W-1:0]  pick_idx,
    output logic              fire,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_data
);

    // Lowest set slot wins, so the drain runs in ascending slot order.
    always_comb begin
        pick_any = 1'b0;
        pick_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (mask[i]) begin
                pick_any = 1'b1;
                pick_idx = IDX_W'(i);
            end
        end
    end

    assign fire = enable && pick_any;

    always_ff @(posedge clk) begin
        if (rst) begin
            arr_we   <= 1'b0;
            arr_addr <= '0;
            arr_data <= '0;
        end else begin
            arr_we <= fire;
            if (fire) begin
                arr_addr <= {page, pick_idx};
                arr_data <= rd_data;
            end
        end
    end

endmodule

// File: rtl/page_write_cache.sv
module page_write_cache
    import pwc_pkg::*;
#(
    parameter int ADDR_W        = DEF_ADDR_W,
    parameter int DATA_W        = DEF_DATA_W,
    parameter int LINES         = DEF_LINES,
    parameter int LINE_BYTES    = DEF_LINE_BYTES,
    parameter int SETTLE_CYCLES = DEF_SETTLE,
    localparam int SLOTS  = LINES * LINE_BYTES,
    localparam int IDX_W  = $clog2(SLOTS),
    localparam int PAGE_W = ADDR_W - IDX_W,
    localparam int CNT_W  = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop_in,
    input  logic              abort_in,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_data
);

    pwc_state_e        state;
    pwc_ctrl_t         ctrl;
    logic [CNT_W-1:0]  settle_cnt;
    logic [PAGE_W-1:0] page;
    logic [IDX_W-1:0]  ptr;
    logic [SLOTS-1:0]  mask;
    logic [IDX_W-1:0]  pick_idx;
    logic              pick_any;
    logic              fire;
    logic [DATA_W-1:0] rd_data;

    assign ctrl = decode_ctrl(state, wr_start, byte_valid, stop_in, abort_in);
    assign busy = is_busy(state);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= PWC_IDLE;
            settle_cnt <= '0;
        end else begin
            unique case (state)
                PWC_IDLE:   if (ctrl.open) state <= PWC_FILL;
                PWC_FILL: begin
                    if (ctrl.discard)        state <= PWC_IDLE;
                    else if (ctrl.go_commit) state <= PWC_DRAIN;
                end
                PWC_DRAIN: begin
                    if (!pick_any) begin
                        state      <= PWC_SETTLE;
                        settle_cnt <= CNT_W'(SETTLE_CYCLES - 1);
                    end
                end
                PWC_SETTLE: begin
                    if (settle_cnt == '0) state <= PWC_IDLE;
                    else                  settle_cnt <= settle_cnt - 1'b1;
                end
                default: state <= PWC_IDLE;
            endcase
        end
    end

    pwc_addr_track #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (ctrl.open),
        .load_addr (start_addr),
        .bump      (ctrl.take_byte),
        .page      (page),
        .ptr       (ptr)
    );

    pwc_slot_store #(
        .DATA_W (DATA_W),
        .SLOTS  (SLOTS)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ctrl.take_byte),
        .wr_idx  (ptr),
        .wr_data (byte_data),
        .clr_all (ctrl.discard),
        .clr_en  (fire),
        .clr_idx (pick_idx),
        .rd_idx  (pick_idx),
        .rd_data (rd_data),
        .mask    (mask)
    );

    pwc_drain_port #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SLOTS  (SLOTS)
    ) u_drain (
        .clk      (clk),
        .rst      (rst),
        .enable   (state == PWC_DRAIN),
        .mask     (mask),
        .page     (page),
        .rd_data  (rd_data),
        .pick_any (pick_any),
        .pick_idx (pick_idx),
        .fire     (fire),
        .arr_we   (arr_we),
        .arr_addr (arr_addr),
        .arr_data (arr_data)
    );

endmodule

// File: rtl/pwc_checker.sv
module pwc_checker
    import pwc_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int IDX_W  = 6,
    parameter int SLOTS  = 64,
    localparam int PAGE_W = ADDR_W - IDX_W
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr,
    input logic              byte_valid,
    input logic              stop_in,
    input logic              abort_in,
    input pwc_state_e        state,
    input logic [IDX_W-1:0]  ptr,
    input logic [PAGE_W-1:0] page,
    input logic [SLOTS-1:0]  mask
);

    assert_write_only_busy_R5: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> busy);

    assert_drain_ascending_R5: assert property (@(posedge clk) disable iff (rst)
        (arr_we && $past(arr_we)) |-> (arr_addr[IDX_W-1:0] > $past(arr_addr[IDX_W-1:0])));

    assert_mask_empty_at_end_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (mask == '0));

    assert_ptr_step_R2: assert property (@(posedge clk) disable iff (rst)
        (state == PWC_FILL && byte_valid && !stop_in && !abort_in)
        |=> (ptr == IDX_W'($past(ptr) + 1'b1)));

    assert_page_held_R4: assert property (@(posedge clk) disable iff (rst)
        (state == PWC_FILL) |=> $stable(page));

    assert_write_page_R4: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> (arr_addr[ADDR_W-1:IDX_W] == page));

    assert_abort_clean_R8: assert property (@(posedge clk) disable iff (rst)
        (state == PWC_FILL && abort_in) |=> (mask == '0 && !busy));

    assert_busy_no_fill_R9: assert property (@(posedge clk) disable iff (rst)
        busy |=> (state != PWC_FILL));

endmodule

bind page_write_cache pwc_checker #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .SLOTS  (SLOTS)
) u_pwc_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .arr_we     (arr_we),
    .arr_addr   (arr_addr),
    .byte_valid (byte_valid),
    .stop_in    (stop_in),
    .abort_in   (abort_in),
    .state      (state),
    .ptr        (ptr),
    .page       (page),
    .mask       (mask)
);

// File: tb/page_write_cache_test.sv
module page_write_cache_test;

    localparam int SETTLE = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_start = 1'b0;
    logic [12:0] start_addr = '0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        stop_in = 1'b0;
    logic        abort_in = 1'b0;
    logic        busy;
    logic        arr_we;
    logic [12:0] arr_addr;
    logic [7:0]  arr_data;

    int n_checks = 0;
    int n_fail   = 0;
    int cap_cnt  = 0;
    int busy_cnt = 0;
    logic [12:0] cap_addr [128];
    logic [7:0]  cap_data [128];

    always #2.5 clk = ~clk;

    page_write_cache #(.SETTLE_CYCLES(SETTLE)) uut (
        .clk(clk), .rst(rst), .wr_start(wr_start), .start_addr(start_addr),
        .byte_valid(byte_valid), .byte_data(byte_data), .stop_in(stop_in),
        .abort_in(abort_in), .busy(busy), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_data(arr_data)
    );

    // Port monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (arr_we) begin
            if (cap_cnt < 128) begin
                cap_addr[cap_cnt] = arr_addr;
                cap_data[cap_cnt] = arr_data;
            end
            cap_cnt++;
        end
        if (busy) busy_cnt++;
    end

    // {start address, byte count, first data value}
    localparam logic [28:0] VEC [6] = '{
        {13'h0A05, 8'd1,  8'h3C},  // R6 single byte, R1 start slot
        {13'h1F3E, 8'd5,  8'h11},  // R3 wrap 63 -> 0
        {13'h0006, 8'd3,  8'hA0},  // R2 line roll 6,7,8
        {13'h0410, 8'd64, 8'h02},  // R4 full cache
        {13'h1234, 8'd70, 8'h55},  // R3 overwrite of earlier slots
        {13'h07C0, 8'd0,  8'h00}   // R7 stop with no bytes
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic open_burst(input logic [12:0] sa);
        @(negedge clk);
        wr_start   = 1'b1;
        start_addr = sa;
        @(negedge clk);
        wr_start   = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d);
        byte_valid = 1'b1;
        byte_data  = d;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic send_stop();
        cap_cnt  = 0;
        busy_cnt = 0;
        stop_in  = 1'b1;
        @(negedge clk);
        stop_in  = 1'b0;
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 300 && busy; g++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_burst(input logic [12:0] sa, input int n, input logic [7:0] seed,
                             input string tag);
        bit         mv [64];
        logic [7:0] md [64];
        int         p;
        int         nv;
        int         k;
        for (int s = 0; s < 64; s++) begin mv[s] = 1'b0; md[s] = '0; end
        p = int'(sa[5:0]);
        open_burst(sa);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = seed + 8'(i * 7);
            mv[p] = 1'b1;
            md[p] = d;
            p = (p + 1) % 64;
            send_byte(d);
        end
        send_stop();
        wait_idle();
        nv = 0;
        for (int s = 0; s < 64; s++) if (mv[s]) nv++;
        k = 0;
        for (int s = 0; s < 64; s++) begin
            if (mv[s]) begin
                logic [12:0] ea;
                ea = {sa[12:6], 6'(s)};
                if (k < cap_cnt && k < 128) begin
                    chk(cap_addr[k] == ea, "R4 addr", int'(cap_addr[k]), int'(ea));
                    chk(cap_data[k] == md[s], "R4 data", int'(cap_data[k]), int'(md[s]));
                end else begin
                    chk(1'b0, "R5 missing write", k, int'(ea));
                end
                k++;
            end
        end
        chk(cap_cnt == nv, {tag, " R5 write count"}, cap_cnt, nv);
        chk(busy_cnt == nv + 1 + SETTLE, {tag, " R7 busy cycles"}, busy_cnt, nv + 1 + SETTLE);
    endtask

    initial begin
        repeat (1000) @(posedge clk);
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(busy == 1'b0, "R11 busy after reset", int'(busy), 0);
        chk(arr_we == 1'b0, "R11 we after reset", int'(arr_we), 0);

        // Vector table
        for (int v = 0; v < 6; v++)
            run_burst(VEC[v][28:16], int'(VEC[v][15:8]), VEC[v][7:0], "vec");

        // R8 abort discards, no writes, no busy
        open_burst(13'h0333);
        for (int i = 0; i < 4; i++) send_byte(8'hC0 + 8'(i));
        cap_cnt = 0; busy_cnt = 0;
        abort_in = 1'b1;
        @(negedge clk);
        abort_in = 1'b0;
        repeat (10) @(negedge clk);
        chk(cap_cnt == 0, "R8 abort writes", cap_cnt, 0);
        chk(busy_cnt == 0, "R8 abort busy", busy_cnt, 0);
        // R8 next burst has no stale bytes from the aborted one
        run_burst(13'h0335, 1, 8'h99, "R8");

        // R10 abort and stop together: abort wins
        open_burst(13'h0100);
        send_byte(8'h12);
        cap_cnt = 0; busy_cnt = 0;
        abort_in = 1'b1; stop_in = 1'b1;
        @(negedge clk);
        abort_in = 1'b0; stop_in = 1'b0;
        repeat (10) @(negedge clk);
        chk(cap_cnt == 0, "R10 abort over stop writes", cap_cnt, 0);
        chk(busy_cnt == 0, "R10 abort over stop busy", busy_cnt, 0);

        // R10 byte in the stop cycle is dropped
        open_burst(13'h0800);
        send_byte(8'h41);
        send_byte(8'h42);
        byte_valid = 1'b1; byte_data = 8'hEE;
        send_stop();
        byte_valid = 1'b0;
        wait_idle();
        chk(cap_cnt == 2, "R10 byte with stop count", cap_cnt, 2);
        chk(cap_data[1] == 8'h42, "R10 last data", int'(cap_data[1]), 8'h42);
        chk(busy_cnt == 2 + 1 + SETTLE, "R10 busy cycles", busy_cnt, 2 + 1 + SETTLE);

        // R9 requests while busy are ignored
        open_burst(13'h0A00);
        for (int i = 0; i < 3; i++) send_byte(8'h70 + 8'(i));
        send_stop();
        wr_start = 1'b1; start_addr = 13'h1500;
        @(negedge clk);
        wr_start = 1'b0;
        send_byte(8'hDD);
        stop_in = 1'b1;
        @(negedge clk);
        stop_in = 1'b0;
        wait_idle();
        repeat (10) @(negedge clk);
        chk(cap_cnt == 3, "R9 writes while busy", cap_cnt, 3);
        chk(busy == 1'b0, "R9 idle after busy", int'(busy), 0);
        chk(busy_cnt == 3 + 1 + SETTLE, "R9 busy not extended", busy_cnt, 3 + 1 + SETTLE);

        // R9 byte and stop while idle are ignored
        cap_cnt = 0; busy_cnt = 0;
        for (int i = 0; i < 3; i++) send_byte(8'hB0 + 8'(i));
        stop_in = 1'b1;
        @(negedge clk);
        stop_in = 1'b0;
        repeat (8) @(negedge clk);
        chk(busy_cnt == 0, "R9 idle stop busy", busy_cnt, 0);
        chk(cap_cnt == 0, "R9 idle stop writes", cap_cnt, 0);
        open_burst(13'h0040);
        send_stop();
        wait_idle();
        chk(cap_cnt == 0, "R9 idle bytes not kept", cap_cnt, 0);
        chk(busy_cnt == 1 + SETTLE, "R7 empty commit busy", busy_cnt, 1 + SETTLE);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule